// File: doc/BRIEF.md
# Compare-Match Event Timer Channel

This block is one timer channel that raises timing events from a programmable compare value. A prescaler gives four divided taps of the system clock and also passes through a slow-clock tick pulse. The selected tick drives an up-counter. In periodic use, the counter returns to zero after it passes the compare value and keeps running, so it produces an event train with a fixed period. When the halt-on-match bit is set, the first match also switches the channel's clock off. This gives a one-shot delay, and software re-arms it by loading a new compare value and issuing a start command.

Software reaches the channel through a small register bus with single-cycle strobes and registered read data. A command register enables, disables and restarts the counter. A sticky match flag is cleared when the status register is read. A one-bit interrupt mask is set and cleared through separate enable and disable registers. The interrupt line is registered. The counter width is a parameter, 16 or 32 bits.

Top module: `cmt_event_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low. The addresses are 0 mode, 1 compare, 5 mask, 6 status and 7 count.
- R2: Mode bits [2:0] select the tick source. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 clocks. After a start command, the count read back n clocks later equals floor(n / divisor).
- R3: Tick select value 4 advances the counter once for each clock in which `slow_tick` is high. The divided taps then have no effect.
- R4: With mode bit 4 (auto-reset) set, the counter goes from the compare value C back to 0 on the next tick. The count after n clocks is floor(n/D) mod (C+1).
- R5: With mode bit 5 (halt-on-match) set, the tick that brings the counter to C also stops the clock. The counter holds C, and status bit 1 (running) reads 0.
- R6: A match sets status bit 0 in the same clock that the counter reaches C. A read of status (address 6) clears it, so a second read returns 0.
- R7: Writing 1 to bit 0 of address 3 sets the mask, and address 5 reads it back. With the mask set, `irq` rises one clock after the match flag sets and falls one clock after the status read that clears the flag.
- R8: Writing 0xFF to address 4 clears the mask. A pending match flag then does not raise `irq`.
- R9: Command bits (address 2) are: bit 0 enable, bit 1 disable, bit 2 start. If enable and disable are written together, disable wins, the running bit reads 0, and the count does not move.
- R10: Writing enable and start together clears the counter and the prescaler and starts counting. This re-arms a halted one-shot, which then produces another match.
- R11: With compare 2^W−1 and halt-on-match set, the longest delay is 2^W−1 ticks. The counter stops at 2^W−1 and does not wrap.
- R12: With mode bit 3 (waveform enable) clear, the counter does not advance, even while the running bit is set.
- R13: With auto-reset clear, the counter runs freely, wraps from 2^W−1 to 0, and still flags the match at C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after `bus_rd` |
| slow_tick | input | 1 | Slow-clock tick pulse, synchronous to `clk` |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong prescaler phase or a wrong reload boundary shows up as a count value that is off by one within one divisor period of the start command. The bench catches this because it sweeps read-back points around every multiple of each divisor. A faulty halt or a missing clear of the flag leaves the running bit set, or lets the count move past C. Both are visible in the next status or count read. Mask or interrupt-timing faults show on `irq` in exactly the clock after the flag changes. The bench samples `irq` on both sides of that clock.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IDIS = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd7;

  localparam int CMD_EN   = 0;
  localparam int CMD_DIS  = 1;
  localparam int CMD_TRIG = 2;

  localparam int ST_MATCH = 0;
  localparam int ST_RUN   = 1;

  localparam int NUM_TAPS = 4;
  localparam logic [2:0] SEL_SLOW = 3'd4;

  typedef struct packed {
    logic       stop;
    logic       auto_rst;
    logic       wave;
    logic [2:0] sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);
  localparam int PRE_W = 2 * TAPS - 1;
  localparam int IDX_W = $clog2(TAPS);

  logic [PRE_W-1:0] pre;
  logic [TAPS-1:0]  tap_hit;

  always_ff @(posedge clk) begin
    if (rst || restart) pre <= '0;
    else                pre <= pre + PRE_W'(1);
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_hit[g] = &pre[2*g:0];
  end

  always_comb begin
    tick = 1'b0;
    if (sel == SEL_SLOW)       tick = slow_tick;
    else if (sel < 3'(TAPS))   tick = tap_hit[sel[IDX_W-1:0]];
  end

  p_restart_phase_r10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pre == '0));
endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter
  import cmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_en,
  input  logic         cmd_dis,
  input  logic         cmd_trig,
  input  mode_t        mode,
  input  logic [W-1:0] cmp,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         running,
  output logic         hit
);
  logic         cmd_any, adv, at_cmp, wrap_now;
  logic [W-1:0] inc;

  assign cmd_any  = cmd_en | cmd_dis | cmd_trig;
  assign adv      = running & mode.wave & tick & ~cmd_any;
  assign at_cmp   = (count == cmp);
  assign inc      = count + W'(1);
  assign wrap_now = mode.auto_rst & at_cmp;
  assign hit      = adv & ~wrap_now & (inc == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      if (cmd_dis)     running <= 1'b0;
      else if (cmd_en) running <= 1'b1;

      if (cmd_trig) begin
        count <= '0;
      end else if (adv) begin
        count <= wrap_now ? '0 : inc;
        if (hit && mode.stop) running <= 1'b0;
      end
    end
  end

  p_oneshot_halts_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && mode.stop) |=> !running);
  p_reload_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && mode.auto_rst && at_cmp) |=> (count == '0));
  p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!running && !cmd_trig) |=> (count == $past(count)));
  p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_trig |=> (count == '0));
endmodule

// File: rtl/cmt_regs.sv
`timescale 1ns/1ps
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int W      = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [W-1:0]      count,
  input  logic              running,
  input  logic              hit,
  output mode_t             mode,
  output logic [W-1:0]      cmp,
  output logic              cmd_en,
  output logic              cmd_dis,
  output logic              cmd_trig,
  output logic              irq
);
  logic              mask_q, flag_q;
  logic              wr_cmd, wr_ien, wr_idis, rd_stat;
  logic [DATA_W-1:0] rd_mux, mode_ext, cmp_ext, cnt_ext;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_cmd   = bus_wr && (bus_addr == A_CMD);
  assign wr_ien   = bus_wr && (bus_addr == A_IEN);
  assign wr_idis  = bus_wr && (bus_addr == A_IDIS);
  assign rd_stat  = bus_rd && (bus_addr == A_STAT);
  assign cmd_en   = wr_cmd && bus_wdata[CMD_EN];
  assign cmd_dis  = wr_cmd && bus_wdata[CMD_DIS];
  assign cmd_trig = wr_cmd && bus_wdata[CMD_TRIG];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '0;
      cmp       <= '0;
      mask_q    <= 1'b0;
      flag_q    <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) mode <= mode_t'(bus_wdata[MODE_W-1:0]);
      if (bus_wr && bus_addr == A_CMP)  cmp  <= bus_wdata[W-1:0];

      if (wr_idis && bus_wdata[ST_MATCH])     mask_q <= 1'b0;
      else if (wr_ien && bus_wdata[ST_MATCH]) mask_q <= 1'b1;

      if (hit)          flag_q <= 1'b1;
      else if (rd_stat) flag_q <= 1'b0;

      irq <= flag_q & mask_q;

      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  always_comb begin
    mode_ext = '0;
    mode_ext[MODE_W-1:0] = mode;
    cmp_ext = '0;
    cmp_ext[W-1:0] = cmp;
    cnt_ext = '0;
    cnt_ext[W-1:0] = count;
    rd_mux = '0;
    case (bus_addr)
      A_MODE: rd_mux = mode_ext;
      A_CMP:  rd_mux = cmp_ext;
      A_MASK: rd_mux[ST_MATCH] = mask_q;
      A_STAT: begin
        rd_mux[ST_MATCH] = flag_q;
        rd_mux[ST_RUN]   = running;
      end
      A_CNT:  rd_mux = cnt_ext;
      default: rd_mux = '0;
    endcase
  end

  p_flag_on_match_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
  p_flag_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !hit) |=> !flag_q);
  p_disable_masks_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_idis && bus_wdata[ST_MATCH]) |=> !mask_q);
  p_dis_beats_en_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_dis |=> !running);
endmodule

// File: rtl/cmt_event_timer.sv
`timescale 1ns/1ps
module cmt_event_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slow_tick,
  output logic              irq
);
  mode_t            mode;
  logic [CNT_W-1:0] cmp, count;
  logic             cmd_en, cmd_dis, cmd_trig;
  logic             tick, running, hit;

  cmt_regs #(.W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .running(running), .hit(hit),
    .mode(mode), .cmp(cmp),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(cmd_trig),
    .irq(irq)
  );

  cmt_prescaler #(.TAPS(NUM_TAPS)) u_pre (
    .clk(clk), .rst(rst), .restart(cmd_trig),
    .sel(mode.sel), .slow_tick(slow_tick), .tick(tick)
  );

  cmt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(cmd_trig),
    .mode(mode), .cmp(cmp), .tick(tick),
    .count(count), .running(running), .hit(hit)
  );
endmodule

// File: tb/cmt_event_timer_bench.sv
`timescale 1ns/1ps
module cmt_event_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, slow_tick = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  cmt_event_timer #(.CNT_W(16), .DATA_W(32)) u_cmt_event_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slow_tick(slow_tick), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mw(int sel, bit wave, bit autor, bit stop);
    return 32'(sel) | (32'(wave) << 3) | (32'(autor) << 4) | (32'(stop) << 5);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd1, v); chk("R1 compare", v, 0);
    rd(3'd5, v); chk("R1 mask", v, 0);
    rd(3'd6, v); chk("R1 status", v, 0);
    rd(3'd7, v); chk("R1 count", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 divided taps
    wr(3'd1, 32'hFFFF);
    for (int s = 0; s < 4; s++) begin
      int d;
      d = 2 << (2 * s);
      wr(3'd0, mw(s, 1, 0, 0));
      for (int j = 0; j < 7; j++) begin
        int n;
        case (j)
          0: n = 0;      1: n = d - 1;  2: n = d;      3: n = d + 1;
          4: n = 2*d-1;  5: n = 2*d;    default: n = 3*d + 1;
        endcase
        wr(3'd2, 32'h5);
        idle(n);
        rd(3'd7, v);
        chk($sformatf("R2 sel%0d n%0d", s, n), v, 32'(n / d));
      end
    end

    // R12 waveform enable clear
    wr(3'd0, mw(0, 0, 0, 0));
    wr(3'd2, 32'h5);
    idle(20);
    rd(3'd7, v); chk("R12 count frozen", v, 0);
    rd(3'd6, v); chk("R12 running", v, 32'h2);

    // R4 periodic reload
    wr(3'd1, 32'd3);
    wr(3'd0, mw(0, 1, 1, 0));
    for (int n = 0; n <= 40; n++) begin
      wr(3'd2, 32'h5);
      idle(n);
      rd(3'd7, v);
      chk($sformatf("R4 n%0d", n), v, 32'((n / 2) % 4));
    end
    rd(3'd6, v);

    // R5 one-shot halt
    wr(3'd1, 32'd4);
    wr(3'd0, mw(1, 1, 1, 1));
    wr(3'd2, 32'h5);
    for (int i = 0; i < 50; i++) begin
      rd(3'd7, v);
      chk($sformatf("R5 i%0d", i), v, 32'((i / 8) < 4 ? (i / 8) : 4));
    end
    rd(3'd6, v); chk("R5 halted with flag", v, 32'h1);

    // R10 re-arm
    wr(3'd2, 32'h5);
    for (int i = 0; i < 41; i++) begin
      rd(3'd7, v);
      chk($sformatf("R10 i%0d", i), v, 32'((i / 8) < 4 ? (i / 8) : 4));
    end
    rd(3'd6, v); chk("R10 new match", v, 32'h1);

    // R6 flag set and read-clear, mask clear
    wr(3'd1, 32'd2);
    wr(3'd0, mw(0, 1, 1, 1));
    wr(3'd2, 32'h5);
    idle(7);
    chk("R6 masked irq", 32'(irq), 0);
    rd(3'd6, v); chk("R6 flag set", v, 32'h1);
    rd(3'd6, v); chk("R6 flag cleared", v, 32'h0);

    // R7 mask and irq timing
    wr(3'd3, 32'h1);
    rd(3'd5, v); chk("R7 mask readback", v, 32'h1);
    wr(3'd2, 32'h5);
    idle(4);
    chk("R7 irq before", 32'(irq), 0);
    idle(1);
    chk("R7 irq rise", 32'(irq), 1);
    rd(3'd6, v); chk("R7 status", v, 32'h1);
    chk("R7 irq held", 32'(irq), 1);
    idle(1);
    chk("R7 irq fall", 32'(irq), 0);

    // R8 disable all
    wr(3'd4, 32'hFF);
    rd(3'd5, v); chk("R8 mask cleared", v, 32'h0);
    wr(3'd2, 32'h5);
    idle(10);
    chk("R8 irq blocked", 32'(irq), 0);
    rd(3'd6, v); chk("R8 flag pending", v, 32'h1);

    // R9 disable beats enable
    wr(3'd1, 32'hFFFF);
    wr(3'd0, mw(0, 1, 0, 0));
    wr(3'd2, 32'h5);
    wr(3'd2, 32'h3);
    rd(3'd6, v); chk("R9 not running", v, 32'h0);
    idle(10);
    rd(3'd7, v); chk("R9 count held", v, 32'h0);

    // R3 slow tick source
    wr(3'd0, mw(4, 1, 0, 0));
    wr(3'd2, 32'h5);
    for (int i = 0; i < 30; i++) begin
      slow_tick = (i % 3 == 0);
      @(negedge clk);
    end
    slow_tick = 1'b0;
    rd(3'd7, v); chk("R3 slow count", v, 32'd10);

    // R11 longest one-shot
    wr(3'd0, mw(4, 1, 1, 1));
    slow_tick = 1'b1;
    wr(3'd2, 32'h5);
    idle(65535);
    rd(3'd7, v); chk("R11 reached max", v, 32'hFFFF);
    idle(10);
    rd(3'd7, v); chk("R11 no wrap", v, 32'hFFFF);
    rd(3'd6, v); chk("R11 halted flag", v, 32'h1);

    // R13 free-running wrap
    wr(3'd1, 32'd5);
    wr(3'd0, mw(4, 1, 0, 0));
    wr(3'd2, 32'h5);
    idle(65536 + 3);
    rd(3'd7, v); chk("R13 wrapped count", v, 32'd3);
    slow_tick = 1'b0;
    rd(3'd6, v); chk("R13 flag and running", v, 32'h3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule